// File: doc/BRIEF.md
# Floppy Drive Sense and Command Responder

This block is the drive side of a floppy-drive link. A controller drives four select lines and a strobe. It reads one sense bit back. The select lines pick one of sixteen sense conditions, such as motor state or track zero. Most of these are active low. A rising edge on the strobe runs a command. The lower three select lines choose the command, and the top line carries its on/off value.

Inside, the block keeps the following state:
- head position and step direction
- a timed step operation
- spindle motor and tachometer
- disk presence
- a timed eject operation
- a latched disk-changed flag
- the active head

Disk insertion, the write-protect tab and the side count come from configuration inputs. All durations are parameters counted in clock cycles.

Top module: `drive_sense_unit`

## Requirements
- R1: After reset the block is in this state: track 0, direction inward, motor off, no disk, disk-changed flag inactive (sense 1), lower head, and no step or eject in progress.
- R2: `sense_o` is combinational on `sel_i` = {CA2,CA1,CA0,SEL}. The codes are:
  - 0000: direction, 1 = outward
  - 0001: 1 = no disk
  - 0010: 0 = stepping
  - 0011: `write_ok_i`
  - 0100: 0 = motor on
  - 0101: 0 = at track 0
  - 0110: disk-changed flag, 0 = ejected
  - 0111: tachometer
  - 1000 and 1001: 0
  - 1100: `two_side_i`
  - 1101: ready, 0 = ready
  - 1111: 0, meaning the drive is installed
  - 1010, 1011 and 1110: 1
- R3: A strobe rise with `sel_i[2:0]`=000 sets the direction to `sel_i[3]`, where 0 is inward and 1 is outward.
- R4: A strobe rise with `sel_i`=0010 starts a step. When the step ends, the track moves by one: up for inward, down for outward. It holds at 0 going outward and at MAX_TRACK going inward.
- R5: A step keeps the stepping sense at 0 for exactly STEP_CYC cycles. Track 0 sense changes only when the step ends. A step command given during a step is ignored.
- R6: Command 0100 turns the motor on and command 1100 turns it off. Ready (code 1101) is 0 exactly when three things hold: the motor is on, no step is running, and a disk is present.
- R7: While the motor runs, the tachometer toggles every TACH_HALF cycles. While the motor is off, it stays at 0.
- R8: Command 1110 starts an eject. At once it clears disk presence and the motor, and sets the disk-changed sense to 0. For EJECT_CYC cycles afterwards, all commands and insertions are ignored.
- R9: Command 1001 sets the disk-changed sense back to 1.
- R10: While `sel_i` is 1000 the lower head is chosen, and while it is 1001 the upper head is chosen. `head_upper_o` follows one cycle later.
- R11: A one-cycle pulse on `insert_i` outside an eject makes a disk present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 4 | {CA2,CA1,CA0,SEL} select lines |
| strobe_i | input | 1 | Command strobe; its rising edge executes a command |
| insert_i | input | 1 | Disk insertion pulse |
| write_ok_i | input | 1 | 1 = media is write-enabled |
| two_side_i | input | 1 | 1 = double-sided drive |
| sense_o | output | 1 | Selected sense bit |
| head_upper_o | output | 1 | 1 = upper head chosen |
| track_o | output | 7 | Current head track |

## Verification
A wrong internal state can only show through `sense_o`, `track_o` or `head_upper_o`.

- A corrupted step counter changes how long the stepping sense stays at 0. The bench measures that width cycle by cycle.
- A wrong track update shows on `track_o`, and on the track-zero sense, once the step ends.
- An eject lock that leaks lets the motor sense fall within a few cycles of a command given during the eject.
- A missing head latch shows on `head_upper_o` one cycle after the select code changes.

// File: rtl/drv_pkg.sv
// Shared codes for the drive responder: sense select codes and command indices.
// Assumes sel = {CA2,CA1,CA0,SEL}; command index = {CA1,CA0,SEL}.
package drv_pkg;
    localparam logic [3:0] SN_DIR     = 4'b0000;
    localparam logic [3:0] SN_EMPTY   = 4'b0001;
    localparam logic [3:0] SN_STEP    = 4'b0010;
    localparam logic [3:0] SN_WREN    = 4'b0011;
    localparam logic [3:0] SN_MOTOR   = 4'b0100;
    localparam logic [3:0] SN_TRK0    = 4'b0101;
    localparam logic [3:0] SN_CHANGED = 4'b0110;
    localparam logic [3:0] SN_TACH    = 4'b0111;
    localparam logic [3:0] SN_HEAD_LO = 4'b1000;
    localparam logic [3:0] SN_HEAD_HI = 4'b1001;
    localparam logic [3:0] SN_SIDES   = 4'b1100;
    localparam logic [3:0] SN_READY   = 4'b1101;
    localparam logic [3:0] SN_INSTALL = 4'b1111;

    typedef enum logic [2:0] {
        CMD_DIR    = 3'b000,
        CMD_CLRCHG = 3'b001,
        CMD_STEP   = 3'b010,
        CMD_MOTOR  = 3'b100,
        CMD_EJECT  = 3'b110
    } drv_cmd_e;
endpackage

// File: rtl/drv_stepper.sv
// Head positioner: holds the step direction and the track number, and runs a timed step.
// Assumes step_go is a single-cycle pulse. The direction is captured when the step starts.
module drv_stepper #(
    parameter int MAX_TRACK = 79,
    parameter int STEP_CYC  = 600000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               dir_wr,
    input  logic                               dir_val,
    input  logic                               step_go,
    output logic                               dir_out_o,
    output logic [$clog2(MAX_TRACK+1)-1:0]     track_o,
    output logic                               busy_o
);
    localparam int TW = $clog2(MAX_TRACK + 1);
    localparam int CW = $clog2(STEP_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          step_dir_q;

    // Direction register, step timer and track update at the end of each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_out_o  <= 1'b0;
            track_o    <= '0;
            busy_o     <= 1'b0;
            cnt_q      <= '0;
            step_dir_q <= 1'b0;
        end else begin
            if (dir_wr) dir_out_o <= dir_val;
            if (step_go && !busy_o) begin
                busy_o     <= 1'b1;
                cnt_q      <= CW'(STEP_CYC - 1);
                step_dir_q <= dir_out_o;
            end else if (busy_o) begin
                if (cnt_q == '0) begin
                    busy_o <= 1'b0;
                    if (step_dir_q && track_o != '0)
                        track_o <= track_o - 1'b1;
                    else if (!step_dir_q && track_o != TW'(MAX_TRACK))
                        track_o <= track_o + 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/drv_spindle.sv
// Spindle motor state and the tachometer square wave.
// Assumes the on, off and stop inputs are single-cycle pulses. stop outranks off, and off outranks on.
module drv_spindle #(
    parameter int TACH_HALF = 41667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_go,
    input  logic off_go,
    input  logic stop,
    output logic motor_o,
    output logic tach_o
);
    localparam int TCW = $clog2(TACH_HALF + 1);

    logic [TCW-1:0] tcnt_q;

    // Motor on/off register.
    always_ff @(posedge clk) begin
        if (!rst_n)                motor_o <= 1'b0;
        else if (stop || off_go)   motor_o <= 1'b0;
        else if (on_go)            motor_o <= 1'b1;
    end

    // Tachometer: toggle every TACH_HALF cycles while spinning.
    always_ff @(posedge clk) begin
        if (!rst_n || !motor_o) begin
            tcnt_q <= '0;
            tach_o <= 1'b0;
        end else if (tcnt_q == TCW'(TACH_HALF - 1)) begin
            tcnt_q <= '0;
            tach_o <= ~tach_o;
        end else begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/drv_media.sv
// Media tracker: disk presence, the timed eject and the latched disk-changed flag.
// Assumes all inputs are single-cycle pulses. Insertion is refused while an eject is running.
module drv_media #(
    parameter int EJECT_CYC = 25000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic insert_i,
    input  logic eject_go,
    input  logic clr_go,
    output logic present_o,
    output logic changed_n_o,
    output logic ej_busy_o
);
    localparam int ECW = $clog2(EJECT_CYC + 1);

    logic [ECW-1:0] ecnt_q;

    // Presence, disk-changed flag and eject timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_o   <= 1'b0;
            changed_n_o <= 1'b1;
            ej_busy_o   <= 1'b0;
            ecnt_q      <= '0;
        end else if (ej_busy_o) begin
            if (ecnt_q == '0) ej_busy_o <= 1'b0;
            else              ecnt_q    <= ecnt_q - 1'b1;
        end else if (eject_go) begin
            present_o   <= 1'b0;
            changed_n_o <= 1'b0;
            ej_busy_o   <= 1'b1;
            ecnt_q      <= ECW'(EJECT_CYC - 1);
        end else begin
            if (insert_i) present_o   <= 1'b1;
            if (clr_go)   changed_n_o <= 1'b1;
        end
    end
endmodule

// File: rtl/drive_sense_unit.sv
// Drive-side responder: decodes strobed commands and multiplexes sixteen sense conditions onto sense_o.
// Assumes the inputs are synchronous to clk. sel_i must be stable while strobe_i rises.
module drive_sense_unit #(
    parameter int MAX_TRACK = 79,
    parameter int STEP_CYC  = 600000,
    parameter int EJECT_CYC = 25000000,
    parameter int TACH_HALF = 41667
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [3:0]                      sel_i,
    input  logic                            strobe_i,
    input  logic                            insert_i,
    input  logic                            write_ok_i,
    input  logic                            two_side_i,
    output logic                            sense_o,
    output logic                            head_upper_o,
    output logic [$clog2(MAX_TRACK+1)-1:0]  track_o
);
    import drv_pkg::*;

    logic     strobe_q;
    logic     cmd_ok;
    logic     cmd_val;
    drv_cmd_e cmd_idx;
    logic     dir_out, step_busy, motor_on, tach, present, changed_n, ej_busy;
    logic     dir_wr, step_go, on_go, off_go, clr_go, eject_go;

    // Strobe edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    // Command decode: accepted only on a strobe rise outside an eject.
    always_comb begin
        cmd_ok   = strobe_i && !strobe_q && !ej_busy;
        cmd_val  = sel_i[3];
        cmd_idx  = drv_cmd_e'(sel_i[2:0]);
        dir_wr   = cmd_ok && cmd_idx == CMD_DIR;
        step_go  = cmd_ok && cmd_idx == CMD_STEP   && !cmd_val;
        on_go    = cmd_ok && cmd_idx == CMD_MOTOR  && !cmd_val;
        off_go   = cmd_ok && cmd_idx == CMD_MOTOR  &&  cmd_val;
        clr_go   = cmd_ok && cmd_idx == CMD_CLRCHG &&  cmd_val;
        eject_go = cmd_ok && cmd_idx == CMD_EJECT  &&  cmd_val;
    end

    // Head choice follows the head-data select codes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  head_upper_o <= 1'b0;
        else if (sel_i == SN_HEAD_LO) head_upper_o <= 1'b0;
        else if (sel_i == SN_HEAD_HI) head_upper_o <= 1'b1;
    end

    drv_stepper #(.MAX_TRACK(MAX_TRACK), .STEP_CYC(STEP_CYC)) u_step (
        .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dir_val(cmd_val),
        .step_go(step_go), .dir_out_o(dir_out), .track_o(track_o), .busy_o(step_busy)
    );

    drv_spindle #(.TACH_HALF(TACH_HALF)) u_spin (
        .clk(clk), .rst_n(rst_n), .on_go(on_go), .off_go(off_go), .stop(eject_go),
        .motor_o(motor_on), .tach_o(tach)
    );

    drv_media #(.EJECT_CYC(EJECT_CYC)) u_media (
        .clk(clk), .rst_n(rst_n), .insert_i(insert_i), .eject_go(eject_go),
        .clr_go(clr_go), .present_o(present), .changed_n_o(changed_n), .ej_busy_o(ej_busy)
    );

    // Sense multiplexer, mostly active-low conditions.
    always_comb begin
        case (sel_i)
            SN_DIR:     sense_o = dir_out;
            SN_EMPTY:   sense_o = ~present;
            SN_STEP:    sense_o = ~step_busy;
            SN_WREN:    sense_o = write_ok_i;
            SN_MOTOR:   sense_o = ~motor_on;
            SN_TRK0:    sense_o = (track_o != '0);
            SN_CHANGED: sense_o = changed_n;
            SN_TACH:    sense_o = tach;
            SN_HEAD_LO: sense_o = 1'b0;
            SN_HEAD_HI: sense_o = 1'b0;
            SN_SIDES:   sense_o = two_side_i;
            SN_READY:   sense_o = ~(motor_on && !step_busy && present);
            SN_INSTALL: sense_o = 1'b0;
            default:    sense_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/drv_checker.sv
// Property checker for drive_sense_unit; attached through bind.
// Assumes it sees the top's internal step, eject, presence and motor state.
module drv_checker #(
    parameter int MAX_TRACK = 79
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [3:0]                     sel_i,
    input logic [$clog2(MAX_TRACK+1)-1:0] track_o,
    input logic                           step_busy,
    input logic                           ej_busy,
    input logic                           present,
    input logic                           motor_on,
    input logic                           head_upper_o
);
    // R4
    track_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        track_o <= ($clog2(MAX_TRACK+1))'(MAX_TRACK));

    // R5
    track_at_step_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (track_o != $past(track_o)) |-> ($past(step_busy) && !step_busy));

    // R8
    eject_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ej_busy) |-> !$rose(motor_on));

    // R8
    eject_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ej_busy) |-> (!present && !motor_on));

    // R10
    head_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 4'b1001) |=> head_upper_o);
endmodule

bind drive_sense_unit drv_checker #(.MAX_TRACK(MAX_TRACK)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .track_o(track_o),
    .step_busy(step_busy), .ej_busy(ej_busy), .present(present),
    .motor_on(motor_on), .head_upper_o(head_upper_o)
);

// File: tb/drive_sense_unit_test.sv
module drive_sense_unit_test;
    localparam int STEP = 20, EJ = 60, HALF = 4, MAXT = 79;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel_i = 4'b0;
    logic       strobe_i = 1'b0, insert_i = 1'b0, write_ok_i = 1'b1, two_side_i = 1'b0;
    logic       sense_o, head_upper_o;
    logic [6:0] track_o;

    always #10 clk = ~clk;

    drive_sense_unit #(.MAX_TRACK(MAXT), .STEP_CYC(STEP), .EJECT_CYC(EJ), .TACH_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .strobe_i(strobe_i), .insert_i(insert_i),
        .write_ok_i(write_ok_i), .two_side_i(two_side_i), .sense_o(sense_o),
        .head_upper_o(head_upper_o), .track_o(track_o)
    );

    int checks = 0, errors = 0, cyc = 0;
    int  m_track = 0;
    bit  m_dir = 0, m_motor = 0, m_present = 0, m_chg_n = 1, m_head = 0;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_sense(logic [3:0] c);
        case (c)
            4'b0000: return m_dir;
            4'b0001: return !m_present;
            4'b0010: return 1'b1;
            4'b0011: return write_ok_i;
            4'b0100: return !m_motor;
            4'b0101: return m_track != 0;
            4'b0110: return m_chg_n;
            4'b0111: return 1'b0;
            4'b1000, 4'b1001, 4'b1111: return 1'b0;
            4'b1100: return two_side_i;
            4'b1101: return !(m_motor && m_present);
            default: return 1'b1;
        endcase
    endfunction

    // Reads one sense code when the block is idle. Codes 0010 and 0111 hold constants only when no step runs and the motor is off.
    task automatic sense_chk(logic [3:0] c, string tag);
        @(negedge clk); sel_i = c; #1;
        if (!(c == 4'b0111 && m_motor)) chk(tag, sense_o, exp_sense(c));
        if (c == 4'b1000) m_head = 0;
        if (c == 4'b1001) m_head = 1;
    endtask

    task automatic raw_cmd(logic [3:0] c);
        @(negedge clk); sel_i = c; strobe_i = 1'b1;
        @(negedge clk); strobe_i = 1'b0;
    endtask

    task automatic cmd(logic [3:0] c);
        raw_cmd(c);
        if (c == 4'b1000) m_head = 0;
        if (c == 4'b1001) m_head = 1;
        case (c[2:0])
            3'b000: m_dir = c[3];
            3'b010: if (!c[3]) begin
                        if (m_dir && m_track > 0) m_track--;
                        else if (!m_dir && m_track < MAXT) m_track++;
                    end
            3'b100: m_motor = !c[3];
            3'b001: if (c[3]) m_chg_n = 1;
            3'b110: if (c[3]) begin m_present = 0; m_motor = 0; m_chg_n = 0; end
            default: ;
        endcase
    endtask

    task automatic step_wait();
        cmd(4'b0010);
        repeat (STEP + 2) @(negedge clk);
    endtask

    task automatic insert();
        @(negedge clk); insert_i = 1'b1;
        @(negedge clk); insert_i = 1'b0;
        m_present = 1;
    endtask

    initial begin
        void'($urandom(32'h1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through every sense code
        for (int i = 0; i < 16; i++) sense_chk(4'(i), "R1/R2 reset sense");
        chk("R1 reset track", track_o, 0);
        @(negedge clk); chk("R10 head after 1001 code", head_upper_o, 1);
        sense_chk(4'b1000, "R2 lower head code");
        @(negedge clk); chk("R10 head after 1000 code", head_upper_o, 0);

        // R4: an outward step at track 0 holds
        cmd(4'b1000); sense_chk(4'b0000, "R3 dir outward");
        step_wait(); chk("R4 saturate at 0", track_o, 0);
        cmd(4'b0000); sense_chk(4'b0000, "R3 dir inward");

        // R11: insertion and configuration inputs
        insert(); sense_chk(4'b0001, "R11 disk present");
        write_ok_i = 1'b0; sense_chk(4'b0011, "R2 protected");
        write_ok_i = 1'b1; two_side_i = 1'b1; sense_chk(4'b1100, "R2 two sided");

        // R5/R6: busy width, ready during a step, track-zero timing
        cmd(4'b0100); sense_chk(4'b1101, "R6 ready");
        raw_cmd(4'b0010);
        begin
            int n = 0;
            sel_i = 4'b0101; #1; chk("R5 trk0 unchanged during step", sense_o, 0);
            sel_i = 4'b1101; #1; chk("R6 not ready while stepping", sense_o, 1);
            sel_i = 4'b0010;
            for (int k = 0; k < STEP + 5; k++) begin
                #1; if (!sense_o) n++;
                if (k == 3) begin strobe_i = 1'b1; @(negedge clk); strobe_i = 1'b0; k++; #1; if (!sense_o) n++; end
                @(negedge clk);
            end
            chk("R5 busy width", n, STEP);
        end
        m_track = 1;
        chk("R5 second step ignored", track_o, 1);
        sense_chk(4'b0101, "R4 off track 0");
        cmd(4'b1000); step_wait();
        sense_chk(4'b0101, "R4 back at track 0");

        // R4: saturation at MAX_TRACK
        cmd(4'b0000);
        for (int k = 0; k < MAXT + 2; k++) step_wait();
        chk("R4 saturate at max", track_o, MAXT);

        // R7: tachometer
        begin
            int rises = 0; bit prev;
            @(negedge clk); sel_i = 4'b0111; #1; prev = sense_o;
            for (int k = 0; k < 8 * HALF; k++) begin
                @(negedge clk); #1;
                if (sense_o && !prev) rises++;
                prev = sense_o;
            end
            chk("R7 tach rises", rises, 4);
            cmd(4'b1100);
            rises = 0;
            for (int k = 0; k < 8 * HALF; k++) begin
                @(negedge clk); sel_i = 4'b0111; #1; if (sense_o) rises++;
            end
            chk("R7 tach idle when off", rises, 0);
        end

        // R8: eject and its lockout
        cmd(4'b0100);
        cmd(4'b1110);
        sense_chk(4'b0001, "R8 eject empties");
        sense_chk(4'b0100, "R8 eject stops motor");
        sense_chk(4'b0110, "R8 changed flag");
        raw_cmd(4'b0100);
        @(negedge clk); @(negedge clk); insert_i = 1'b1; @(negedge clk); insert_i = 1'b0;
        sense_chk(4'b0100, "R8 motor cmd ignored");
        sense_chk(4'b0001, "R8 insert ignored");
        repeat (EJ + 2) @(negedge clk);
        cmd(4'b0100); sense_chk(4'b0100, "R6 motor on after eject");
        cmd(4'b1001); sense_chk(4'b0110, "R9 changed cleared");
        @(negedge clk); chk("R10 head upper", head_upper_o, 1);
        insert(); sense_chk(4'b1101, "R6 ready again");
        cmd(4'b1100);

        // Random mix checked against the model
        for (int it = 0; it < 60; it++) begin
            int r = $urandom % 5;
            case (r)
                0: cmd(4'b0000);
                1: cmd(4'b1000);
                2: step_wait();
                3: cmd(4'b0100);
                default: cmd(4'b1100);
            endcase
            sense_chk(4'($urandom % 16), "R2 random sense");
            chk("R4 random track", track_o, m_track);
        end
        @(negedge clk); chk("R10 head model", head_upper_o, m_head);
        finish_run();
    end
endmodule